// File: doc/BRIEF.md
# Counted Step Pulse Burst Generator

The block drives the step and direction inputs of an external stepper driver that sequences the motor phases itself. Software writes a period (in system clock cycles), a pulse count, a direction and a two-bit step-size code, then issues a start command. The block then emits exactly that many step pulses at the programmed rate and stops by itself. A hardware down counter, decremented once per emitted pulse, gates the pulse timer off at zero. No processor action is needed while a burst runs.

Completion is latched in a sticky done bit that software polls or takes as an interrupt. Software clears the bit by writing one to it, or a new start clears it. The generator makes every high and every low phase of the step output last at least the driver's minimum time. Any period shorter than the minimum frame is stretched to that frame. An abort command ends a burst cleanly after the pulse in flight completes its low phase, and the count still unsent can then be read back.

Register map on the 3-bit address (32-bit data):

- 0: command, write-only. Bit 0 is start, bit 1 is abort.
- 1: period in cycles.
- 2: pulse count.
- 3: configuration. Bit 0 is direction, bits 2:1 are step size, bit 3 is interrupt enable.
- 4: status. Bit 0 is done; writing 1 to bit 0 clears it. Bit 1 is busy.
- 5: remaining count, read-only.

Top module: `stepgen_burst`

## Requirements
- R1: After reset, step_o, dir_o, msel_o and irq_o are 0, and the status (address 4), period (address 1) and count (address 2) read as 0.
- R2: A start (write 1 to bit 0 of address 0) with count N>0 emits exactly N rising edges on step_o. After that, step_o stays low, status bit 0 (done) is 1 and status bit 1 (busy) is 0.
- R3: With effective period Pe, each pulse is high for floor(Pe/2) cycles, and the low time between pulses is Pe-floor(Pe/2) cycles.
- R4: A period below twice MIN_HALF_CYC is replaced by 2*MIN_HALF_CYC. With the defaults (50 MHz, 1 us), MIN_HALF_CYC is 50, so such a period gives 50 cycles high and 50 cycles low. Every high and every low phase lasts at least MIN_HALF_CYC cycles.
- R5: A start with N=0 emits no pulse. Done reads 1 on the cycle after the start write, and busy stays 0.
- R6: dir_o follows configuration bit 0 and msel_o follows configuration bits 2:1 while idle or in a low phase. Both hold their value while step_o is high.
- R7: An abort (write 1 to bit 1 of address 0) during a burst lets the current pulse finish its low phase, then ends the burst with done set. Address 5 then reads N minus the pulses emitted. An abort while idle has no effect on the next burst.
- R8: Done is sticky. Writing status with bit 0 = 1 clears it, writing bit 0 = 0 leaves it set, and a start clears it.
- R9: irq_o is high exactly when done is 1 and configuration bit 3 is 1.
- R10: A start, or a count write, while busy does not change the running burst's pulse total.
- R11: Busy reads 1 from the cycle after an accepted start with N>0 until the last low phase ends. It is never 1 together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | write address |
| wr_data_i | input | 32 | write data |
| rd_addr_i | input | 3 | read address |
| rd_data_o | output | 32 | read data, combinational |
| step_o | output | 1 | step pulse to driver |
| dir_o | output | 1 | direction to driver |
| msel_o | output | 2 | step-size select to driver |
| irq_o | output | 1 | completion interrupt request |

## Verification
The bench walks a set of bursts that vary period and count, including periods below the minimum frame and odd periods. For each burst it measures the run lengths of the high and low phases and counts the pulses. A design off by one in the down counter would emit N±1 pulses, and one that failed to clamp would emit a frame shorter than the driver accepts. Directed cases cover a zero count, which must finish with no pulse; an abort during a pulse, which must not cut the pulse short and must leave the correct residue; a restart while busy, which must not reload the count; and a direction change written during a high phase, which a wrong design would pass through to the driver mid-pulse. Write-one-to-clear is checked against a write of zero, which a wrong design would also treat as a clear.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } run_st_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_REMAIN = 3'd5;
endpackage

// File: rtl/stepgen_regs.sv
module stepgen_regs
  import stepgen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  remain_i,
  output logic [PER_W-1:0]  period_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic [1:0]        msel_o,
  output logic              irq_en_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              clr_o
);
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] count_q;
  logic             dir_q;
  logic [1:0]       msel_q;
  logic             irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      count_q  <= '0;
      dir_q    <= 1'b0;
      msel_q   <= 2'b00;
      irq_en_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_PERIOD: period_q <= wr_data_i[PER_W-1:0];
        A_COUNT:  count_q  <= wr_data_i[CNT_W-1:0];
        A_CFG: begin
          dir_q    <= wr_data_i[0];
          msel_q   <= wr_data_i[2:1];
          irq_en_q <= wr_data_i[3];
        end
        default: ;
      endcase
    end
  end

  assign start_o = wr_en_i && (wr_addr_i == A_CMD)  && wr_data_i[0];
  assign abort_o = wr_en_i && (wr_addr_i == A_CMD)  && wr_data_i[1];
  assign clr_o   = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_PERIOD: rd_data_o[PER_W-1:0] = period_q;
      A_COUNT:  rd_data_o[CNT_W-1:0] = count_q;
      A_CFG:    rd_data_o[3:0]       = {irq_en_q, msel_q, dir_q};
      A_STAT:   rd_data_o[1:0]       = {busy_i, done_i};
      A_REMAIN: rd_data_o[CNT_W-1:0] = remain_i;
      default:  rd_data_o = '0;
    endcase
  end

  assign period_o = period_q;
  assign count_o  = count_q;
  assign dir_o    = dir_q;
  assign msel_o   = msel_q;
  assign irq_en_o = irq_en_q;
endmodule

// File: rtl/stepgen_split.sv
module stepgen_split #(
  parameter int unsigned PER_W        = 16,
  parameter int unsigned MIN_HALF_CYC = 50
) (
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] hi_o,
  output logic [PER_W-1:0] lo_o
);
  localparam logic [PER_W-1:0] MIN_FRAME = PER_W'(2 * MIN_HALF_CYC);

  logic [PER_W-1:0] p_eff;

  // stretch short periods so both phases meet the driver minimum
  assign p_eff = (period_i < MIN_FRAME) ? MIN_FRAME : period_i;
  assign hi_o  = p_eff >> 1;
  assign lo_o  = p_eff - hi_o;
endmodule

// File: rtl/stepgen_core.sv
module stepgen_core
  import stepgen_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             clr_i,
  input  logic [PER_W-1:0] hi_i,
  input  logic [PER_W-1:0] lo_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_dir_i,
  input  logic [1:0]       cfg_msel_i,
  output logic             step_o,
  output logic             dir_o,
  output logic [1:0]       msel_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remain_o
);
  run_st_e          st_q;
  logic [PER_W-1:0] tmr_q;
  logic [PER_W-1:0] hi_q;
  logic [PER_W-1:0] lo_q;
  logic [CNT_W-1:0] remain_q;
  logic             abort_q;
  logic             done_q;
  logic             dir_q;
  logic [1:0]       msel_q;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tmr_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      remain_q <= '0;
      abort_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (clr_i) done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          abort_q <= 1'b0;
          if (start_i) begin
            hi_q     <= hi_i;
            lo_q     <= lo_i;
            remain_q <= cnt_i;
            tmr_q    <= hi_i - PER_W'(1);
            if (cnt_i == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q <= 1'b0;
              st_q   <= ST_HIGH;
            end
          end
        end
        ST_HIGH: begin
          if (abort_i) abort_q <= 1'b1;
          if (tmr_zero) begin
            st_q     <= ST_LOW;
            tmr_q    <= lo_q - PER_W'(1);
            remain_q <= remain_q - CNT_W'(1);
          end else begin
            tmr_q <= tmr_q - PER_W'(1);
          end
        end
        ST_LOW: begin
          if (abort_i) abort_q <= 1'b1;
          if (tmr_zero) begin
            // down counter at zero or abort pending gates the timer off
            if (remain_q == '0 || abort_q || abort_i) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q  <= ST_HIGH;
              tmr_q <= hi_q - PER_W'(1);
            end
          end else begin
            tmr_q <= tmr_q - PER_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // driver setup lines never move while step is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      msel_q <= 2'b00;
    end else if (st_q != ST_HIGH) begin
      dir_q  <= cfg_dir_i;
      msel_q <= cfg_msel_i;
    end
  end

  assign step_o   = (st_q == ST_HIGH);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign remain_o = remain_q;
  assign dir_o    = dir_q;
  assign msel_o   = msel_q;
endmodule

// File: rtl/stepgen_burst.sv
module stepgen_burst
  import stepgen_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned MIN_HALF_NS = 1000,
  parameter int unsigned PER_W       = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              step_o,
  output logic              dir_o,
  output logic [1:0]        msel_o,
  output logic              irq_o
);
  localparam int unsigned MIN_HALF_CYC =
    int'((longint'(CLK_HZ) * longint'(MIN_HALF_NS) + 64'd999_999_999) / 64'd1_000_000_000);

  logic [PER_W-1:0] period_w, hi_w, lo_w;
  logic [CNT_W-1:0] count_w, remain_w;
  logic             cfg_dir_w, irq_en_w;
  logic [1:0]       cfg_msel_w;
  logic             start_w, abort_w, clr_w;
  logic             done_w, busy_w;

  stepgen_regs #(
    .DATA_W(DATA_W), .PER_W(PER_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .done_i   (done_w),
    .busy_i   (busy_w),
    .remain_i (remain_w),
    .period_o (period_w),
    .count_o  (count_w),
    .dir_o    (cfg_dir_w),
    .msel_o   (cfg_msel_w),
    .irq_en_o (irq_en_w),
    .start_o  (start_w),
    .abort_o  (abort_w),
    .clr_o    (clr_w)
  );

  stepgen_split #(
    .PER_W(PER_W), .MIN_HALF_CYC(MIN_HALF_CYC)
  ) u_split (
    .period_i(period_w),
    .hi_o    (hi_w),
    .lo_o    (lo_w)
  );

  stepgen_core #(
    .PER_W(PER_W), .CNT_W(CNT_W)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .abort_i   (abort_w),
    .clr_i     (clr_w),
    .hi_i      (hi_w),
    .lo_i      (lo_w),
    .cnt_i     (count_w),
    .cfg_dir_i (cfg_dir_w),
    .cfg_msel_i(cfg_msel_w),
    .step_o    (step_o),
    .dir_o     (dir_o),
    .msel_o    (msel_o),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .remain_o  (remain_w)
  );

  assign irq_o = done_w & irq_en_w;
endmodule

// File: rtl/stepgen_burst_chk.sv
module stepgen_burst_chk #(
  parameter int unsigned MIN_HALF_CYC = 50,
  parameter int unsigned CNT_W        = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_o,
  input logic             dir_o,
  input logic [1:0]       msel_o,
  input logic             irq_o,
  input logic             busy_w,
  input logic             done_w,
  input logic             start_w,
  input logic [CNT_W-1:0] count_w
);
  int unsigned hrun_q, lrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hrun_q <= 0;
      lrun_q <= MIN_HALF_CYC;
    end else if (step_o) begin
      hrun_q <= hrun_q + 1;
      lrun_q <= 0;
    end else begin
      hrun_q <= 0;
      if (lrun_q < MIN_HALF_CYC) lrun_q <= lrun_q + 1;
    end
  end

  p_hold_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && $past(step_o)) |-> ($stable(dir_o) && $stable(msel_o)));

  p_min_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_o) |-> (hrun_q >= MIN_HALF_CYC));

  p_min_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> (lrun_q >= MIN_HALF_CYC));

  p_zero_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && !busy_w && count_w == '0) |=> (done_w && !step_o && !busy_w));

  p_done_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_w && busy_w));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_w |-> !step_o);

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_w);
endmodule

bind stepgen_burst stepgen_burst_chk #(
  .MIN_HALF_CYC(MIN_HALF_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .step_o (step_o),
  .dir_o  (dir_o),
  .msel_o (msel_o),
  .irq_o  (irq_o),
  .busy_w (busy_w),
  .done_w (done_w),
  .start_w(start_w),
  .count_w(count_w)
);

// File: tb/stepgen_burst_tb.sv
module stepgen_burst_tb;
  localparam int MINH = 50;
  localparam int NV   = 6;
  // period, count, dir, msel
  localparam int VEC [NV][4] = '{
    '{100, 3, 1, 2},
    '{101, 2, 0, 1},
    '{40,  2, 1, 3},
    '{250, 4, 0, 0},
    '{0,   1, 1, 1},
    '{1000, 1, 0, 2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        step, dir, irq;
  logic [1:0]  msel;

  int total = 0, bad = 0, cycles = 0;
  int ptot = 0, hrun = 0, lrun = 0, last_hi = 0, last_lo = 0;
  logic prev_step = 1'b0;
  bit   finished = 0;

  always #10 clk = ~clk;

  stepgen_burst u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .step_o(step), .dir_o(dir), .msel_o(msel), .irq_o(irq)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (step && !prev_step) begin
      ptot = ptot + 1;
      if (lrun > 0) last_lo = lrun;
      lrun = 0;
    end
    if (step) hrun = hrun + 1;
    else begin
      if (hrun > 0) begin last_hi = hrun; lrun = 0; end
      hrun = 0;
      lrun = lrun + 1;
    end
    prev_step = step;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 60000; i++) begin
      rd(3'd4, s);
      if (s[0]) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 190000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] r;
    int base, pe, hi, lo;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(step == 0 && dir == 0 && msel == 0 && irq == 0, "R1 outputs", {step, dir, msel, irq}, 0);
    rd(3'd4, r); chk(r == 0, "R1 status", r, 0);
    rd(3'd1, r); chk(r == 0, "R1 period", r, 0);
    rd(3'd2, r); chk(r == 0, "R1 count", r, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      pe = (VEC[v][0] < 2 * MINH) ? 2 * MINH : VEC[v][0];
      hi = pe / 2;
      lo = pe - hi;
      wr(3'd1, VEC[v][0]);
      wr(3'd2, VEC[v][1]);
      wr(3'd3, VEC[v][2] | (VEC[v][3] << 1));
      base = ptot;
      wr(3'd0, 1);
      wait_done();
      repeat (5) @(negedge clk);
      chk(ptot - base == VEC[v][1], "R2 pulse count", ptot - base, VEC[v][1]);
      chk(step == 0, "R2 step low after burst", step, 0);
      rd(3'd4, r); chk(r[1:0] == 2'b01, "R2 done/busy", r[1:0], 1);
      rd(3'd5, r); chk(r == 0, "R2 remain", r, 0);
      chk(last_hi == hi, (VEC[v][0] < 2 * MINH) ? "R4 clamped high" : "R3 high time", last_hi, hi);
      if (VEC[v][1] >= 2)
        chk(last_lo == lo, (VEC[v][0] < 2 * MINH) ? "R4 clamped low" : "R3 low time", last_lo, lo);
      chk(dir == VEC[v][2][0] && msel == VEC[v][3][1:0], "R6 setup lines", {dir, msel}, VEC[v][2] | (VEC[v][3] << 1));
    end

    // R5 zero count, R9 interrupt
    wr(3'd3, 32'h8);
    wr(3'd2, 0);
    wr(3'd4, 1);
    base = ptot;
    wr(3'd0, 1);
    rd(3'd4, r); chk(r[1:0] == 2'b01, "R5 done after zero start", r[1:0], 1);
    chk(irq == 1, "R9 irq with enable", irq, 1);
    repeat (20) @(negedge clk);
    chk(ptot == base, "R5 no pulse", ptot - base, 0);
    // R8 write zero keeps, write one clears
    wr(3'd4, 0);
    rd(3'd4, r); chk(r[0] == 1, "R8 write zero keeps done", r[0], 1);
    wr(3'd4, 1);
    rd(3'd4, r); chk(r[0] == 0, "R8 w1c clears done", r[0], 0);
    chk(irq == 0, "R9 irq drops", irq, 0);
    wr(3'd0, 1);
    wr(3'd3, 32'h0);
    chk(irq == 0, "R9 irq masked", irq, 0);

    // R8 start clears done, R11 busy
    wr(3'd1, 200);
    wr(3'd2, 4);
    wr(3'd0, 1);
    rd(3'd4, r); chk(r[1:0] == 2'b10, "R8 R11 start clears done, sets busy", r[1:0], 2);
    // R6 mid-burst change during low then during high
    while (!(ptot > 0 && !step)) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(3'd3, 32'h7);
    @(negedge clk);
    chk(dir == 1 && msel == 3, "R6 update in low", {dir, msel}, 7);
    while (!step) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(3'd3, 32'h0);
    @(negedge clk);
    chk(step == 1 && dir == 1 && msel == 3, "R6 hold in high", {step, dir, msel}, 15);
    while (step) @(negedge clk);
    @(negedge clk);
    chk(dir == 0 && msel == 0, "R6 update after high", {dir, msel}, 0);
    wait_done();

    // R7 abort mid pulse
    wr(3'd1, 200);
    wr(3'd2, 10);
    base = ptot;
    wr(3'd0, 1);
    while (ptot - base < 3) @(negedge clk);
    wr(3'd0, 2);
    chk(step == 1, "R7 pulse not cut", step, 1);
    wait_done();
    repeat (5) @(negedge clk);
    chk(ptot - base == 3, "R7 pulses before abort", ptot - base, 3);
    chk(last_hi == 100, "R7 last high intact", last_hi, 100);
    rd(3'd5, r); chk(r == 7, "R7 remaining count", r, 7);
    // R7 abort while idle no effect
    wr(3'd0, 2);
    wr(3'd2, 2);
    base = ptot;
    wr(3'd0, 1);
    wait_done();
    repeat (5) @(negedge clk);
    chk(ptot - base == 2, "R7 idle abort ignored", ptot - base, 2);

    // R10 restart and count write while busy
    wr(3'd1, 100);
    wr(3'd2, 3);
    base = ptot;
    wr(3'd0, 1);
    repeat (20) @(negedge clk);
    wr(3'd2, 9);
    wr(3'd0, 1);
    wait_done();
    repeat (5) @(negedge clk);
    chk(ptot - base == 3, "R10 busy start ignored", ptot - base, 3);
    rd(3'd4, r); chk(r[1] == 0, "R11 busy clear at end", r[1], 0);

    finish_run();
  end
endmodule